// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block is the digital core of a supervisory reset generator. It watches three asynchronous inputs: a comparator flag that reports the supply as below its threshold, an external reset request, and a watchdog line on which the host shows that it is alive. From these it produces one system reset output, whose active level is chosen by a parameter, and a write-lockout flag that keeps a nonvolatile memory from being written while the supply is low.

All three reset causes feed a single stretch timer. Whenever any cause is present, the timer is reloaded to its full length. Once all causes have gone away, the reset stays asserted until the timer expires. The watchdog counter is held at zero while reset is active. It only begins to count once reset is released. Glitch rejection, the stretch and the watchdog timeout are all counted in cycles of a free-running clock and are set by parameters, so that a bench can use short values. Every asynchronous input passes through a two-flop synchroniser.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While and after the block's own `rst`, `rst_o` is at its active level and `wr_lock_o` is 0. With no reset cause present, `rst_o` goes inactive on the STRETCH_CYC-th rising edge after `rst` is removed.
- R2: When `supply_low_i` is held at 1, `wr_lock_o` becomes 1 on the (GLITCH_CYC+2)-th edge. `rst_o` becomes active one edge later. Edges are counted from, and including, the first edge that samples the new level.
- R3: A high pulse on `supply_low_i` that lasts fewer than GLITCH_CYC clock cycles changes neither `rst_o` nor `wr_lock_o`.
- R4: After `supply_low_i` returns to 0, `wr_lock_o` clears on the 3rd edge, and `rst_o` goes inactive on edge STRETCH_CYC+3. Both counts include the first edge that samples the 0.
- R5: `ext_rst_i` is level-sensitive. At its active level, it makes `rst_o` active on the 3rd edge and keeps it active. After `ext_rst_i` goes inactive, `rst_o` is released on edge STRETCH_CYC+2. `wr_lock_o` stays 0 throughout.
- R6: If `wd_i` does not change for a whole watchdog period after reset is released, `rst_o` becomes active on the (WDOG_CYC+1)-th edge after the release edge. It then stays active for exactly STRETCH_CYC edges.
- R7: Every change of level on `wd_i`, rising or falling, restarts the watchdog count. Changes that are spaced by fewer than WDOG_CYC cycles therefore keep `rst_o` inactive indefinitely.
- R8: While `rst_o` is active, the watchdog count stays at zero. A reset held for longer than WDOG_CYC adds no extra reset time, and the next timeout is counted from the release.
- R9: RST_ACT_HIGH=1 makes `rst_o` active high, and 0 makes it active low. EXT_ACT_HIGH=1 makes `ext_rst_i` active high, and 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock for all timers |
| rst | input | 1 | Synchronous, active-high power-on reset of the block |
| supply_low_i | input | 1 | Asynchronous comparator flag; 1 means the supply is below threshold |
| ext_rst_i | input | 1 | Asynchronous external reset request; its level is set by EXT_ACT_HIGH |
| wd_i | input | 1 | Asynchronous watchdog line; any change of level counts as activity |
| rst_o | output | 1 | Registered system reset; its level is set by RST_ACT_HIGH |
| wr_lock_o | output | 1 | Registered memory write lockout; 1 while the filtered supply is low |

## Verification
A stretch counter that is loaded or decremented wrongly shows up directly in the release time of `rst_o`. The bench measures that release time to the exact edge after power-on, after supply recovery, after an external request and after a watchdog timeout. A glitch counter that fails to clear between pulses leads to a spurious `wr_lock_o` within a few cycles of a short pulse. A watchdog counter that is not held during reset fires early, within one watchdog period of the release, and a missed edge detect on `wd_i` produces a reset while the host is still toggling the line.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync
  import supv_pkg::*;
#(
  parameter int         WIDTH   = 3,
  parameter logic [2:0] RST_VAL = 3'b000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL[WIDTH-1:0];
      else     stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/supv_glitch_filt.sv
module supv_glitch_filt
  import supv_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = cnt_width(HOLD_CYC);

  if (HOLD_CYC < 2) begin : g_pass
    always_ff @(posedge clk) begin
      if (rst) filt_o <= 1'b0;
      else     filt_o <= raw_i;
    end
  end else begin : g_count
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
      if (rst || !raw_i) begin
        run_q  <= '0;
        filt_o <= 1'b0;
      end else if (run_q == LAST) begin
        filt_o <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end

    // A rise needs the raw flag high on at least the last two samples
    assert_short_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(filt_o) |-> ($past(raw_i) && $past(raw_i, 2)));
  end
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_pkg::*;
#(
  parameter int STRETCH_CYC  = 200000,
  parameter bit RST_ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic active_o,
  output logic rst_o
);
  localparam int            CW   = cnt_width(STRETCH_CYC);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYC);
  localparam logic          INV  = ~RST_ACT_HIGH;

  logic [CW-1:0] left_q, left_n;

  always_comb begin
    if (req_i)              left_n = FULL;
    else if (left_q != '0)  left_n = left_q - 1'b1;
    else                    left_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= FULL;
      active_o <= 1'b1;
      rst_o    <= ~INV;
    end else begin
      left_q   <= left_n;
      active_o <= (left_n != '0);
      rst_o    <= (left_n != '0) ^ INV;
    end
  end

  assert_req_activates_R2: assert property (@(posedge clk) disable iff (rst)
    req_i |=> active_o);

  assert_release_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> !$past(req_i));
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1600000
) (
  input  logic clk,
  input  logic rst,
  input  logic wd_lvl_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam int            CW   = cnt_width(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      idle_q   <= '0;
      expire_o <= 1'b0;
    end else begin
      prev_q   <= wd_lvl_i;
      expire_o <= 1'b0;
      if (hold_i || (wd_lvl_i != prev_q)) begin
        idle_q <= '0;
      end else if (idle_q == LAST) begin
        idle_q   <= '0;
        expire_o <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assert_cleared_in_reset_R8: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (idle_q == '0 && !expire_o));

  assert_kick_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    (wd_lvl_i != prev_q) |=> (idle_q == '0));
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int GLITCH_CYC   = 4,
  parameter int STRETCH_CYC  = 200000,
  parameter int WDOG_CYC     = 1600000,
  parameter bit RST_ACT_HIGH = 1'b1,
  parameter bit EXT_ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic ext_rst_i,
  input  logic wd_i,
  output logic rst_o,
  output logic wr_lock_o
);
  localparam logic EXT_INV = ~EXT_ACT_HIGH;

  logic [2:0] sync_s;
  logic       low_filt, ext_act, wd_expire, any_req, rst_act;

  supv_sync #(
    .WIDTH  (3),
    .RST_VAL({1'b0, EXT_INV, 1'b0})
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i({wd_i, ext_rst_i, supply_low_i}),
    .q_o(sync_s)
  );

  supv_glitch_filt #(.HOLD_CYC(GLITCH_CYC)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .raw_i (sync_s[0]),
    .filt_o(low_filt)
  );

  assign ext_act = sync_s[1] ^ EXT_INV;

  supv_watchdog #(.TIMEOUT_CYC(WDOG_CYC)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .wd_lvl_i(sync_s[2]),
    .hold_i  (rst_act),
    .expire_o(wd_expire)
  );

  assign any_req = low_filt | ext_act | wd_expire;

  supv_stretch #(
    .STRETCH_CYC (STRETCH_CYC),
    .RST_ACT_HIGH(RST_ACT_HIGH)
  ) u_stretch (
    .clk     (clk),
    .rst     (rst),
    .req_i   (any_req),
    .active_o(rst_act),
    .rst_o   (rst_o)
  );

  assign wr_lock_o = low_filt;

  assert_lock_implies_reset_R2: assert property (@(posedge clk) disable iff (rst)
    wr_lock_o |=> rst_act);
endmodule

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb_top;
  localparam int G    = 4;
  localparam int S    = 20;
  localparam int W    = 60;
  localparam int KICK = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low_i = 1'b0;
  logic ext_rst_i = 1'b0;
  logic wd_i = 1'b0;
  logic kick_en = 1'b1;
  logic rst_o, wr_lock_o, rst_n_o, wr_lock_n_o;
  int   checks = 0;
  int   errors = 0;
  int   pol_err = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  supv_reset_ctrl #(.GLITCH_CYC(G), .STRETCH_CYC(S), .WDOG_CYC(W),
                    .RST_ACT_HIGH(1'b1), .EXT_ACT_HIGH(1'b1)) dut_i (
    .clk(clk), .rst(rst), .supply_low_i(supply_low_i), .ext_rst_i(ext_rst_i),
    .wd_i(wd_i), .rst_o(rst_o), .wr_lock_o(wr_lock_o));

  // Inverted-polarity copy: same stimulus, external request driven low-active
  supv_reset_ctrl #(.GLITCH_CYC(G), .STRETCH_CYC(S), .WDOG_CYC(W),
                    .RST_ACT_HIGH(1'b0), .EXT_ACT_HIGH(1'b0)) dut_n (
    .clk(clk), .rst(rst), .supply_low_i(supply_low_i), .ext_rst_i(~ext_rst_i),
    .wd_i(wd_i), .rst_o(rst_n_o), .wr_lock_o(wr_lock_n_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Negedges until rst_o reaches the wanted activity level
  task automatic count_to(input logic want, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_o != want && n < limit);
  endtask

  initial begin : kicker
    int c = 0;
    forever begin
      @(negedge clk);
      if (kick_en) begin
        c++;
        if (c >= KICK) begin
          c = 0;
          wd_i = ~wd_i;
        end
      end else begin
        c = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && (rst_n_o !== ~rst_o || wr_lock_n_o !== wr_lock_o)) pol_err++;
  end

  task automatic t_power_on();
    int n;
    repeat (5) @(negedge clk);
    chk(rst_o == 1'b1, "R1 reset state rst_o", rst_o, 1);
    chk(wr_lock_o == 1'b0, "R1 reset state wr_lock_o", wr_lock_o, 0);
    chk(rst_n_o == 1'b0, "R9 low-active rst_o in reset", rst_n_o, 0);
    rst = 1'b0;
    count_to(1'b0, 4 * S, n);
    chk(n == S, "R1 power-on release edge", n, S);
  endtask

  task automatic t_glitch();
    int seen = 0;
    supply_low_i = 1'b1;
    repeat (G - 1) @(negedge clk);
    supply_low_i = 1'b0;
    repeat (4 * G) begin
      @(negedge clk);
      if (rst_o || wr_lock_o) seen++;
    end
    chk(seen == 0, "R3 short supply pulse ignored", seen, 0);
  endtask

  task automatic t_supply_low();
    int n = 0;
    int lock_clr = 0;
    supply_low_i = 1'b1;
    repeat (G + 2) @(negedge clk);
    chk(wr_lock_o == 1'b1, "R2 wr_lock_o rise edge", wr_lock_o, 1);
    chk(rst_o == 1'b0, "R2 rst_o not yet active", rst_o, 0);
    @(negedge clk);
    chk(rst_o == 1'b1, "R2 rst_o active edge", rst_o, 1);
    repeat (10) @(negedge clk);
    supply_low_i = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (!wr_lock_o && lock_clr == 0) lock_clr = n;
    end while (rst_o && n < 4 * S);
    chk(lock_clr == 3, "R4 wr_lock_o clear edge", lock_clr, 3);
    chk(n == S + 3, "R4 release after supply recovery", n, S + 3);
  endtask

  task automatic t_ext();
    int n;
    int locks = 0;
    ext_rst_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(rst_o == 1'b0, "R5 rst_o before ext latency", rst_o, 0);
    @(negedge clk);
    chk(rst_o == 1'b1, "R5 rst_o active on ext", rst_o, 1);
    repeat (10) begin
      @(negedge clk);
      if (wr_lock_o) locks++;
    end
    chk(locks == 0, "R5 wr_lock_o unaffected", locks, 0);
    ext_rst_i = 1'b0;
    count_to(1'b0, 4 * S, n);
    chk(n == S + 2, "R5 release after ext", n, S + 2);
  endtask

  task automatic t_wd_kick();
    int seen = 0;
    kick_en = 1'b1;
    repeat (4 * W) begin
      @(negedge clk);
      if (rst_o) seen++;
    end
    chk(seen == 0, "R7 regular kicks keep reset off", seen, 0);
  endtask

  task automatic t_wd_timeout();
    int n;
    kick_en = 1'b0;
    ext_rst_i = 1'b1;
    repeat (3) @(negedge clk);
    ext_rst_i = 1'b0;
    count_to(1'b0, 4 * S, n);
    count_to(1'b1, 4 * W, n);
    chk(n == W + 1, "R6 watchdog timeout edge", n, W + 1);
    count_to(1'b0, 4 * S, n);
    chk(n == S, "R6 watchdog reset length", n, S);
    kick_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_wd_held();
    int n;
    int drops = 0;
    kick_en = 1'b0;
    ext_rst_i = 1'b1;
    repeat (3) @(negedge clk);
    repeat (2 * W) begin
      @(negedge clk);
      if (!rst_o) drops++;
    end
    chk(drops == 0, "R8 reset held through long request", drops, 0);
    ext_rst_i = 1'b0;
    count_to(1'b0, 4 * S, n);
    chk(n == S + 2, "R8 no extra reset after long hold", n, S + 2);
    count_to(1'b1, 4 * W, n);
    chk(n == W + 1, "R8 timeout counted from release", n, W + 1);
    count_to(1'b0, 4 * S, n);
    kick_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : main
    t_power_on();
    t_glitch();
    t_supply_low();
    t_ext();
    t_wd_kick();
    t_wd_timeout();
    t_wd_held();
    chk(pol_err == 0, "R9 inverted polarity copy mismatches", pol_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule